// File: doc/BRIEF.md
# Memory-Mapped Watchdog Countdown Timer

This block is a watchdog built around a down-counter and a small register slave port with address, write, writedata, read and readdata signals. The timeout length is a build-time parameter and cannot be changed from the bus. After reset the counter holds its reload value and does not move. Software arms the timer by setting the start bit in the control register. From then on it must keep writing either period register to reload the counter. The data of such a write is ignored. Nothing but a reset can disarm the timer.

If the armed counter runs out, the block raises `rst_req`, a system-wide reset request. `rst_req` stays high until the block's own reset arrives. The request is active high while the block's reset is active low, so the integrator feeds the inverted request into `rst_n`, usually ANDed with the system reset. With that loopback the request clears on the next clock edge, and the timer comes back stopped.

The register map uses word offsets: 0 is status, 1 is control, 2 is the low half of the period and 3 is the high half. In status, bit 1 shows the armed state and bit 0 shows the sticky timeout flag. In control, bit 2 is start and bit 3 is a stop bit that has no effect.

Top module: `wdog_timer`

## Requirements
- R1: During and after reset (`rst_n` low at a clock edge) the timer is stopped. Status reads 0, `rst_req` is 0, and without a start write `rst_req` stays 0 however long the block runs.
- R2: A write to offset 1 with bit 2 set arms the timer. Status bit 1 reads 1 from the cycle after the write edge.
- R3: When armed and not reloaded, `rst_req` rises exactly PERIOD clock edges after the arming write edge, and status bit 0 reads 1 from the same cycle.
- R4: A write to offset 2 or offset 3 with any data reloads an armed counter, so `rst_req` rises exactly PERIOD edges after the last such write.
- R5: Once armed, no write stops the timer or reloads it. This covers writes to offset 1 with bit 3 set, with bit 2 clear, or with bit 2 set again, and writes to offset 0.
- R6: If a reload write falls on the edge where the armed count is zero, the reload wins and `rst_req` does not rise.
- R7: After it rises, `rst_req` and status bit 0 stay at 1 until a reset edge. With `rst_n` driven from the inverted request, the request falls one edge after it rises.
- R8: Writes to offset 2 or 3 while the timer is stopped do not arm it.
- R9: Reads return data in the same cycle as `read`. Offset 1 reads 0. Offsets 2 and 3 read the low and high 16 bits of PERIOD. `readdata` is 0 when `read` is low.
- R10: A reset while the timer is armed returns it to the stopped state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; wire from system reset and inverted `rst_req` |
| address | input | 2 | Register word offset |
| write | input | 1 | Write strobe, one cycle per access |
| writedata | input | 16 | Write data |
| read | input | 1 | Read strobe |
| readdata | output | 16 | Read data, combinational from `address` and `read` |
| rst_req | output | 1 | Sticky reset request, high after a timeout |

## Verification
A reload write and the expiry of the counter can land on the same clock edge. The bench arms the timer, idles PERIOD-1 cycles until the count is zero, and places a period write on exactly the edge where the timeout would otherwise fire. It passes only if `rst_req` stays low there and then rises exactly PERIOD edges after that write. A second overlap is the request meeting its own reset through the loopback. The bench closes that loop and expects the request to last one cycle and the status to return to zero.

// File: rtl/wdog_pkg.sv
// Package wdog_pkg
// Shared register offsets, bit positions and the command bundle that
// passes from the register decoder to the counter.
package wdog_pkg;

    localparam int ADDR_W    = 2;
    localparam int DATA_W    = 16;

    localparam logic [ADDR_W-1:0] OFF_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 2'd1;
    localparam logic [ADDR_W-1:0] OFF_PER_LO = 2'd2;
    localparam logic [ADDR_W-1:0] OFF_PER_HI = 2'd3;

    localparam int NUM_PER_REGS = 2;

    localparam int BIT_TO    = 0;
    localparam int BIT_RUN   = 1;
    localparam int BIT_START = 2;
    localparam int BIT_STOP  = 3;

    typedef struct packed {
        logic start;
        logic kick;
    } wdog_cmd_t;

endpackage

// File: rtl/wdog_regs.sv
// Module wdog_regs
// Decodes bus writes into start and kick commands and builds read data.
// Assumes single-cycle write and read strobes. Read data is combinational.
// The STOP bit and all other write data bits are deliberately ignored.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned PERIOD = 1000
) (
    input  logic [ADDR_W-1:0] address,
    input  logic              write,
    input  logic [DATA_W-1:0] writedata,
    input  logic              read,
    input  logic              run,
    input  logic              to_flag,
    output wdog_cmd_t         cmd,
    output logic [DATA_W-1:0] readdata
);

    localparam logic [63:0]       PERIOD_W = 64'(PERIOD);
    localparam logic [DATA_W-1:0] PER_LO   = PERIOD_W[DATA_W-1:0];
    localparam logic [DATA_W-1:0] PER_HI   = PERIOD_W[2*DATA_W-1:DATA_W];

    logic [NUM_PER_REGS-1:0] per_hit;
    logic                    wdata_unused;

    // Per-offset hit detection for the period registers, which all act as kicks.
    for (genvar g = 0; g < NUM_PER_REGS; g++) begin : g_per_hit
        localparam logic [ADDR_W-1:0] OFF = OFF_PER_LO + ADDR_W'(g);
        assign per_hit[g] = write && (address == OFF);
    end

    // Reduction of the write data bits that carry no function.
    assign wdata_unused = ^{writedata[DATA_W-1:BIT_START+1], writedata[BIT_START-1:0]};

    // Command decode: start from the control register, kick from any period register.
    always_comb begin
        cmd.start = write && (address == OFF_CTRL) && writedata[BIT_START];
        cmd.kick  = |per_hit;
    end

    // Read multiplexer; control reads as zero and period registers show the fixed value.
    always_comb begin
        readdata = '0;
        if (read) begin
            unique case (address)
                OFF_STATUS: begin
                    readdata[BIT_TO]  = to_flag;
                    readdata[BIT_RUN] = run;
                end
                OFF_CTRL:   readdata = '0;
                OFF_PER_LO: readdata = PER_LO;
                OFF_PER_HI: readdata = PER_HI;
                default:    readdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_counter.sv
// Module wdog_counter
// Holds the arm latch and the down-counter. Reset loads PERIOD-1 and
// disarms. Start arms once and loads. Kicks reload only while armed.
// zero_hit flags an expiry that no kick rescued in the same cycle.
// Assumes PERIOD >= 2 and that PERIOD-1 fits in CNT_W bits.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned PERIOD = 1000,
    parameter int          CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdog_cmd_t        cmd,
    output logic             armed,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_hit
);

    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

    logic cnt_zero;

    assign cnt_zero = (cnt == '0);

    // Arm latch: set by start, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed <= 1'b0;
        else if (cmd.start) armed <= 1'b1;
    end

    // Down-counter: load on first start or kick, otherwise count while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= RELOAD;
        end else if (!armed) begin
            if (cmd.start) cnt <= RELOAD;
        end else if (cmd.kick) begin
            cnt <= RELOAD;
        end else if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Expiry: the armed count is zero and no kick arrives in the same cycle.
    assign zero_hit = armed && cnt_zero && !cmd.kick;

endmodule

// File: rtl/wdog_timeout.sv
// Module wdog_timeout
// Turns an expiry into the sticky reset request and the timeout flag.
// Both stay set until reset. Assumes the request is looped back to rst_n.
module wdog_timeout (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_hit,
    output logic rst_req,
    output logic to_flag
);

    // Reset request: set on expiry, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        rst_req <= 1'b0;
        else if (zero_hit) rst_req <= 1'b1;
    end

    // Timeout flag for the status register: same life cycle as the request.
    always_ff @(posedge clk) begin
        if (!rst_n)        to_flag <= 1'b0;
        else if (zero_hit) to_flag <= 1'b1;
    end

endmodule

// File: rtl/wdog_timer.sv
// Module wdog_timer (top)
// Memory-mapped watchdog. Connects the register decoder, the counter and
// the timeout stage. Synchronous active-low reset. The integrator loops
// rst_req back, inverted, into rst_n.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned PERIOD = 1000,
    parameter int          CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        address,
    input  logic              write,
    input  logic [15:0]       writedata,
    input  logic              read,
    output logic [15:0]       readdata,
    output logic              rst_req
);

    wdog_cmd_t        cmd;
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic             zero_hit;
    logic             to_flag;

    // Bus decode and read data.
    wdog_regs #(
        .PERIOD (PERIOD)
    ) u_regs (
        .address   (address),
        .write     (write),
        .writedata (writedata),
        .read      (read),
        .run       (armed),
        .to_flag   (to_flag),
        .cmd       (cmd),
        .readdata  (readdata)
    );

    // Arm latch and countdown.
    wdog_counter #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .armed    (armed),
        .cnt      (cnt),
        .zero_hit (zero_hit)
    );

    // Sticky reset request and timeout flag.
    wdog_timeout u_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_hit (zero_hit),
        .rst_req  (rst_req),
        .to_flag  (to_flag)
    );

endmodule

// File: rtl/wdog_timer_chk.sv
// Module wdog_timer_chk
// Assertion checker bound into wdog_timer. It watches the bus, the arm latch,
// the count and the request.
module wdog_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       address,
    input logic             write,
    input logic [15:0]      writedata,
    input logic             armed,
    input logic [CNT_W-1:0] cnt,
    input logic             to_flag,
    input logic             rst_req
);

    // R1: no request can exist while the timer is stopped.
    assert_no_req_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !rst_req);

    // R2: a start write arms the timer on the next edge.
    assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (write && address == 2'd1 && writedata[2]) |=> armed);

    // R3: the request rises only from a zero count.
    assert_req_from_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(cnt == '0));

    // R5: once armed, the timer stays armed until reset.
    assert_no_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    // R6: a kick on a clear request keeps the request clear.
    assert_kick_blocks_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (write && address[1] && !rst_req) |=> !rst_req);

    // R7: the request and the flag hold until reset.
    assert_req_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (rst_req && to_flag));

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .address   (address),
    .write     (write),
    .writedata (writedata),
    .armed     (armed),
    .cnt       (cnt),
    .to_flag   (to_flag),
    .rst_req   (rst_req)
);

// File: tb/wdog_timer_bench.sv
// Bench for wdog_timer. It walks a vector table of writes, reads and idle
// spans, then runs directed tests for reset, the kick-at-zero overlap and
// the reset loopback. Inputs are driven at the falling edge.
module wdog_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 20;

    localparam logic [1:0] K_WR = 2'd0;
    localparam logic [1:0] K_RD = 2'd1;
    localparam logic [1:0] K_ID = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  addr;
        logic [15:0] data;
        logic [7:0]  n;
        logic        ereq;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{K_RD, 2'd0, 16'h0000, 8'd0,  1'b0, 4'd1},  // R1 status clear after reset
        '{K_ID, 2'd0, 16'h0000, 8'd30, 1'b0, 4'd1},  // R1 idle longer than PERIOD
        '{K_WR, 2'd2, 16'h1234, 8'd0,  1'b0, 4'd8},  // R8 kick while stopped
        '{K_WR, 2'd3, 16'hFFFF, 8'd0,  1'b0, 4'd8},  // R8 kick high while stopped
        '{K_RD, 2'd0, 16'h0000, 8'd0,  1'b0, 4'd8},  // R8 still stopped
        '{K_RD, 2'd1, 16'h0000, 8'd0,  1'b0, 4'd9},  // R9 control reads 0
        '{K_RD, 2'd2, 16'd20,   8'd0,  1'b0, 4'd9},  // R9 period low
        '{K_RD, 2'd3, 16'h0000, 8'd0,  1'b0, 4'd9},  // R9 period high
        '{K_WR, 2'd1, 16'h0004, 8'd0,  1'b0, 4'd2},  // R2 start (edge 0)
        '{K_RD, 2'd0, 16'h0002, 8'd0,  1'b0, 4'd2},  // R2 run bit
        '{K_ID, 2'd0, 16'h0000, 8'd10, 1'b0, 4'd4},  // R4 count 10 edges
        '{K_WR, 2'd3, 16'hFFFF, 8'd0,  1'b0, 4'd4},  // R4 kick, new edge 0
        '{K_ID, 2'd0, 16'h0000, 8'd15, 1'b0, 4'd4},  // R4 edge 15
        '{K_WR, 2'd1, 16'h0008, 8'd0,  1'b0, 4'd5},  // R5 stop bit, edge 16
        '{K_WR, 2'd0, 16'hFFFF, 8'd0,  1'b0, 4'd5},  // R5 status write, edge 17
        '{K_WR, 2'd1, 16'h0004, 8'd0,  1'b0, 4'd5},  // R5 restart no reload, edge 18
        '{K_RD, 2'd0, 16'h0002, 8'd0,  1'b0, 4'd5},  // R5 still running
        '{K_ID, 2'd0, 16'h0000, 8'd1,  1'b0, 4'd4},  // R4 edge 19
        '{K_ID, 2'd0, 16'h0000, 8'd1,  1'b1, 4'd4},  // R4 edge 20 request
        '{K_RD, 2'd0, 16'h0003, 8'd0,  1'b1, 4'd3},  // R3 run and timeout flag
        '{K_ID, 2'd0, 16'h0000, 8'd5,  1'b1, 4'd7},  // R7 request sticky
        '{K_RD, 2'd0, 16'h0003, 8'd0,  1'b1, 4'd7}   // R7 flag sticky
    };

    logic        clk = 1'b0;
    logic        ext_rst_n = 1'b0;
    logic        loop_en = 1'b0;
    logic        rst_n;
    logic [1:0]  address = '0;
    logic        write = 1'b0;
    logic [15:0] writedata = '0;
    logic        read = 1'b0;
    logic [15:0] readdata;
    logic        rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    assign rst_n = ext_rst_n && !(loop_en && rst_req);

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_timer #(.PERIOD(P)) u_wdog_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .address   (address),
        .write     (write),
        .writedata (writedata),
        .read      (read),
        .readdata  (readdata),
        .rst_req   (rst_req)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [15:0] d);
        address = a; writedata = d; write = 1'b1;
        @(posedge clk);
        @(negedge clk);
        write = 1'b0; writedata = '0;
    endtask

    task automatic do_read(input logic [1:0] a, input logic [15:0] exp, input string rq);
        address = a; read = 1'b1;
        #1;
        chk(readdata == exp, rq, int'(readdata), int'(exp));
        read = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_reset();
        ext_rst_n = 1'b0;
        idle(1);
        ext_rst_n = 1'b1;
    endtask

    initial begin
        idle(2);
        chk(rst_req == 1'b0, "R1", int'(rst_req), 0);
        ext_rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[v].rq, v);
            case (VECS[v].kind)
                K_WR: do_write(VECS[v].addr, VECS[v].data);
                K_RD: do_read(VECS[v].addr, VECS[v].data, tag);
                default: idle(int'(VECS[v].n));
            endcase
            chk(rst_req == VECS[v].ereq, tag, int'(rst_req), int'(VECS[v].ereq));
        end

        // R10 / R7: reset clears the request and disarms
        pulse_reset();
        chk(rst_req == 1'b0, "R7 reset clears", int'(rst_req), 0);
        do_read(2'd0, 16'h0000, "R10 status after reset");
        idle(P + 5);
        chk(rst_req == 1'b0, "R10 stays stopped", int'(rst_req), 0);

        // R6: kick on the zero edge wins
        do_write(2'd1, 16'h0004);
        idle(P - 1);
        do_write(2'd2, 16'h0000);
        chk(rst_req == 1'b0, "R6 kick at zero", int'(rst_req), 0);
        idle(P - 1);
        chk(rst_req == 1'b0, "R4 before period", int'(rst_req), 0);
        idle(1);
        chk(rst_req == 1'b1, "R4 at period", int'(rst_req), 1);

        // R7: loopback clears the request one edge later
        pulse_reset();
        loop_en = 1'b1;
        do_write(2'd1, 16'h000C);
        idle(P - 1);
        chk(rst_req == 1'b0, "R3 before period", int'(rst_req), 0);
        idle(1);
        chk(rst_req == 1'b1, "R3 at period", int'(rst_req), 1);
        idle(1);
        chk(rst_req == 1'b0, "R7 loopback clears", int'(rst_req), 0);
        do_read(2'd0, 16'h0000, "R10 stopped after loopback");
        loop_en = 1'b0;
        do_read(2'd0, 16'h0000, "R9 read low gives zero");
        address = 2'd2;
        #1;
        chk(readdata == 16'h0000, "R9 no read strobe", int'(readdata), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule